// File: doc/BRIEF.md
# Configurable Product-Term Logic Block

This block models one programmable sum-of-products logic block. A fixed set of routed input signals enters the block. Each signal is presented to an AND array twice, once as it is and once inverted. Each row of the array is a product term: it is the AND of the columns that its configuration mask selects, gated by a per-term enable bit. The result is a shared pool of product terms.

A steering stage gives each of the 16 sum outputs a fixed number of assignment slots. Each slot names one term of the pool. A sum output is the OR of the terms named by its valid slots. Because several slots, in one sum or in different sums, may name the same term, a term that several outputs need is built only once.

The data path from `in_sig` to `sum_o` is purely combinational. The configuration lives in registers that are loaded through a 32-bit address/data/write-enable port. The configuration is meant to be loaded while the logic is idle, and each write takes effect on the evaluation that follows it.

Top module: `pt_logic_block`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every mask bit, every enable bit and every slot-valid bit is cleared. From then on, and until the next write, `sum_o` is all zeros for any `in_sig`.
- R2: There are 72 array columns. Column i (0..35) carries `in_sig[i]`, and column 36+i carries the inverse of `in_sig[i]`. An enabled term is the AND of the columns its mask selects.
- R3: An enabled term whose mask selects no column evaluates to 1.
- R4: A term whose enable bit is 0 evaluates to 0, whatever its mask and the inputs.
- R5: Each sum output is the OR of the terms named by its valid slots. Each sum has 16 slots, so it can take 0 to 16 terms. A slot whose valid bit is 0 contributes nothing, and every slot position, up to slot 15, is usable.
- R6: A sum with no valid slot outputs 0.
- R7: One term may be named by slots of several sums, and each of those sums follows it.
- R8: A valid slot that names a term index of 86 or above contributes 0.
- R9: The configuration address map works as follows. `cfg_addr[11:10]` selects the region.
  - Region 0 holds term masks. The term is `cfg_addr[9:2]` and the word is `cfg_addr[1:0]`. Word w holds columns 32w..32w+31, and mask bits above column 71 are dropped.
  - Region 1 holds the term enables. Word `cfg_addr[1:0]` holds terms 32w..32w+31.
  - Region 2 holds the slots. The sum is `cfg_addr[9:4]` and the slot is `cfg_addr[3:0]`. `cfg_wdata[7]` is the valid bit and `cfg_wdata[6:0]` is the term index.
  - A write to region 3, to word 3 of region 0 or 1, or to an out-of-range term or sum index changes nothing.
- R10: The configuration changes only at a rising edge with `cfg_we` high. `sum_o` follows `in_sig` in the same cycle, and it reflects a write from the evaluation right after that write's edge.
- R11: An enabled term whose mask selects both polarities of the same input always evaluates to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Synchronous active-low reset of the configuration |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 12 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| in_sig | input | 36 | Routed input signals |
| sum_o | output | 16 | Per-macrocell sum outputs |

## Verification
The bench places its corner terms where an off-by-one decode would misroute them:
- the last term of the pool, whose enable bit lies in the final, partly filled enable word;
- the inverted column of the last input, which is the top bit of the final mask word;
- the last slot of a sum.

A design that decodes the region or word fields wrongly would write into an existing word when it is sent a write to region 3 or to word 3. A sum that was meant to stay constant would then flip.

A term with an empty mask must give 1, while a disabled term and a term holding both polarities of one input must give 0. A design that got any of these wrong would light sums that should stay dark.

A slot pointing past the pool, or marked invalid, must stay silent. Writes presented with `cfg_we` low must leave the outputs unchanged.

// File: rtl/pt_pkg.sv
// Package: shared types of the product-term logic block.
// Assumes: region codes sit in the top two address bits.
package pt_pkg;
    typedef enum logic [1:0] {
        RGN_MASK = 2'd0,
        RGN_EN   = 2'd1,
        RGN_SLOT = 2'd2,
        RGN_NONE = 2'd3
    } cfg_region_e;
endpackage

// File: rtl/pt_cfg_regs.sv
// Module: pt_cfg_regs
// Holds the term masks, term enables and steering slots, and decodes the
// word-wide write port into them.
// Assumes: writes occur while the logic is idle; a synchronous active-low
// reset clears the whole configuration.
module pt_cfg_regs
    import pt_pkg::*;
#(
    parameter int N_IN     = 36,
    parameter int N_PT     = 86,
    parameter int N_SUM    = 16,
    parameter int N_SLOT   = 16,
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int PT_IDX_W = $clog2(N_PT)
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     cfg_we,
    input  logic [ADDR_W-1:0]                        cfg_addr,
    input  logic [DATA_W-1:0]                        cfg_wdata,
    output logic [N_PT-1:0][2*N_IN-1:0]              mask_o,
    output logic [N_PT-1:0]                          term_en_o,
    output logic [N_SUM-1:0][N_SLOT-1:0]             slot_vld_o,
    output logic [N_SUM-1:0][N_SLOT-1:0][PT_IDX_W-1:0] slot_idx_o
);
    localparam int COLS       = 2 * N_IN;
    localparam int WSEL_W     = 2;
    localparam int SLOT_SEL_W = $clog2(N_SLOT);
    localparam int TERM_SEL_W = ADDR_W - 2 - WSEL_W;
    localparam int SUM_SEL_W  = ADDR_W - 2 - SLOT_SEL_W;

    cfg_region_e              region;
    logic [WSEL_W-1:0]        wsel;
    logic [TERM_SEL_W-1:0]    term_sel;
    logic [SLOT_SEL_W-1:0]    slot_sel;
    logic [SUM_SEL_W-1:0]     sum_sel;

    logic [N_PT-1:0][COLS-1:0]                 mask_q;
    logic [N_PT-1:0]                           en_q;
    logic [N_SUM-1:0][N_SLOT-1:0]              vld_q;
    logic [N_SUM-1:0][N_SLOT-1:0][PT_IDX_W-1:0] idx_q;

    // Split the address into its region and index fields.
    always_comb begin
        region   = cfg_region_e'(cfg_addr[ADDR_W-1 -: 2]);
        wsel     = cfg_addr[WSEL_W-1:0];
        term_sel = cfg_addr[WSEL_W +: TERM_SEL_W];
        slot_sel = cfg_addr[SLOT_SEL_W-1:0];
        sum_sel  = cfg_addr[SLOT_SEL_W +: SUM_SEL_W];
    end

    // Mask storage: one word of columns per write, out-of-range indexes dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (cfg_we && region == RGN_MASK) begin
            for (int t = 0; t < N_PT; t++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (int'(term_sel) == t && int'(wsel) == c / DATA_W)
                        mask_q[t][c] <= cfg_wdata[c % DATA_W];
                end
            end
        end
    end

    // Enable storage: 32 term enables per word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (cfg_we && region == RGN_EN) begin
            for (int b = 0; b < N_PT; b++) begin
                if (int'(wsel) == b / DATA_W)
                    en_q[b] <= cfg_wdata[b % DATA_W];
            end
        end
    end

    // Slot storage: valid bit and term index for one slot of one sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            idx_q <= '0;
        end else if (cfg_we && region == RGN_SLOT) begin
            for (int s = 0; s < N_SUM; s++) begin
                for (int k = 0; k < N_SLOT; k++) begin
                    if (int'(sum_sel) == s && int'(slot_sel) == k) begin
                        vld_q[s][k] <= cfg_wdata[PT_IDX_W];
                        idx_q[s][k] <= cfg_wdata[PT_IDX_W-1:0];
                    end
                end
            end
        end
    end

    assign mask_o     = mask_q;
    assign term_en_o  = en_q;
    assign slot_vld_o = vld_q;
    assign slot_idx_o = idx_q;
endmodule

// File: rtl/pt_and_array.sv
// Module: pt_and_array
// Forms every product term as the AND of its selected columns (the inputs
// followed by their inverses), gated by the term's enable bit.
// Assumes: an empty mask yields a constant 1 for an enabled term.
module pt_and_array #(
    parameter int N_IN = 36,
    parameter int N_PT = 86
) (
    input  logic [N_IN-1:0]             in_sig,
    input  logic [N_PT-1:0][2*N_IN-1:0] mask,
    input  logic [N_PT-1:0]             term_en,
    output logic [N_PT-1:0]             pterm
);
    logic [2*N_IN-1:0] cols;

    // Column vector: true polarity low, inverted polarity high.
    assign cols = {~in_sig, in_sig};

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        // Unselected columns are forced to 1 so they drop out of the AND.
        assign pterm[t] = term_en[t] & (&(cols | ~mask[t]));
    end
endmodule

// File: rtl/pt_steer.sv
// Module: pt_steer
// ORs the terms named by each sum's valid slots into that sum's output.
// Assumes: a slot index past the pool reads a zero-padded term.
module pt_steer #(
    parameter int N_PT     = 86,
    parameter int N_SUM    = 16,
    parameter int N_SLOT   = 16,
    parameter int PT_IDX_W = $clog2(N_PT)
) (
    input  logic [N_PT-1:0]                            pterm,
    input  logic [N_SUM-1:0][N_SLOT-1:0]               slot_vld,
    input  logic [N_SUM-1:0][N_SLOT-1:0][PT_IDX_W-1:0] slot_idx,
    output logic [N_SUM-1:0]                           sum_o
);
    localparam int PT_EXT = 2 ** PT_IDX_W;

    logic [PT_EXT-1:0] pt_ext;

    // Zero-pad the pool so every index value selects a defined bit.
    assign pt_ext = PT_EXT'(pterm);

    for (genvar s = 0; s < N_SUM; s++) begin : g_sum
        // Collect the terms of all valid slots of this sum.
        always_comb begin
            sum_o[s] = 1'b0;
            for (int k = 0; k < N_SLOT; k++)
                sum_o[s] = sum_o[s] | (slot_vld[s][k] & pt_ext[slot_idx[s][k]]);
        end
    end
endmodule

// File: rtl/pt_logic_block.sv
// Module: pt_logic_block
// Top of the configurable product-term logic block: the configuration
// registers, the AND array and the steering stage.
// Assumes: configuration is loaded while idle; the data path is combinational.
module pt_logic_block #(
    parameter int N_IN   = 36,
    parameter int N_PT   = 86,
    parameter int N_SUM  = 16,
    parameter int N_SLOT = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [N_IN-1:0]   in_sig,
    output logic [N_SUM-1:0]  sum_o
);
    localparam int PT_IDX_W = $clog2(N_PT);

    logic [N_PT-1:0][2*N_IN-1:0]               mask_w;
    logic [N_PT-1:0]                           term_en_w;
    logic [N_PT-1:0]                           pterm_w;
    logic [N_SUM-1:0][N_SLOT-1:0]              slot_vld_w;
    logic [N_SUM-1:0][N_SLOT-1:0][PT_IDX_W-1:0] slot_idx_w;
    logic [N_SUM*N_SLOT-1:0]                   slot_vld_flat;

    assign slot_vld_flat = slot_vld_w;

    pt_cfg_regs #(
        .N_IN(N_IN), .N_PT(N_PT), .N_SUM(N_SUM), .N_SLOT(N_SLOT),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PT_IDX_W(PT_IDX_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .mask_o(mask_w), .term_en_o(term_en_w),
        .slot_vld_o(slot_vld_w), .slot_idx_o(slot_idx_w)
    );

    pt_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .in_sig(in_sig), .mask(mask_w), .term_en(term_en_w), .pterm(pterm_w)
    );

    pt_steer #(
        .N_PT(N_PT), .N_SUM(N_SUM), .N_SLOT(N_SLOT), .PT_IDX_W(PT_IDX_W)
    ) u_steer (
        .pterm(pterm_w), .slot_vld(slot_vld_w), .slot_idx(slot_idx_w), .sum_o(sum_o)
    );
endmodule

// File: rtl/pt_logic_block_chk.sv
// Module: pt_logic_block_chk
// Property checker bound to pt_logic_block; it watches the term pool, the
// configuration state and the sums.
// Assumes: the bind below supplies the internal nets of the top.
module pt_logic_block_chk #(
    parameter int N_PT   = 86,
    parameter int N_SUM  = 16,
    parameter int N_SLOT = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic [N_SUM-1:0]        sum_o,
    input logic [N_PT-1:0]         pterm,
    input logic [N_PT-1:0]         term_en,
    input logic [N_SUM*N_SLOT-1:0] slot_vld
);
    AST_OFF_TERM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pterm & ~term_en) == '0);  // R4

    AST_SUM_NEEDS_TERM: assert property (@(posedge clk) disable iff (!rst_n)
        (|sum_o) |-> (|pterm));  // R5

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(term_en) && $stable(slot_vld)));  // R10

    for (genvar s = 0; s < N_SUM; s++) begin : g_empty
        AST_EMPTY_SUM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !(|slot_vld[s*N_SLOT +: N_SLOT]) |-> !sum_o[s]);  // R6
    end
endmodule

bind pt_logic_block pt_logic_block_chk #(
    .N_PT(N_PT), .N_SUM(N_SUM), .N_SLOT(N_SLOT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .sum_o(sum_o),
    .pterm(pterm_w), .term_en(term_en_w), .slot_vld(slot_vld_flat)
);

// File: tb/pt_logic_block_bench.sv
module pt_logic_block_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [11:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [35:0] in_sig = '0;
    logic [15:0] sum_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pt_logic_block u_pt_logic_block (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .in_sig(in_sig), .sum_o(sum_o)
    );

    // {in_sig, expected sum_o} for the configuration loaded below
    localparam logic [51:0] VEC [7] = '{
        {36'h0_0000_0000, 16'h8A0A},  // R2 R3 R5 R7: inverted columns only
        {36'h0_0000_0007, 16'h8A0B},  // R2 R7: shared T0 in S0, S1, S15
        {36'h0_0000_000C, 16'h8A48},  // R2: true and inverted mix in T2
        {36'h0_0000_001C, 16'h0A08},  // R2: T2 killed by in4
        {36'h8_0000_0004, 16'h8908},  // R2 R9: last term, last input
        {36'hF_FFFF_FFFF, 16'h890B},  // R4 R8 R11: all ones
        {36'h0_0000_0064, 16'h0A08}   // R4 R11: in5/in6 high
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic we = 1'b1);
        @(negedge clk);
        cfg_we = we;
        cfg_addr = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic apply(input logic [35:0] v);
        @(negedge clk);
        in_sig = v;
        #5;
    endtask

    function automatic logic [11:0] slot_a(input int s, input int k);
        return 12'h800 | 12'(s << 4) | 12'(k);
    endfunction

    initial begin
        // R1: reset state
        in_sig = '1;
        repeat (3) @(posedge clk);
        #5 check("R1 in reset", sum_o, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        apply('1);
        check("R1 after reset", sum_o, 16'h0000);

        // term masks: addr = term<<2 | word
        wr(12'(0 << 2) | 0, 32'h0000_0003);   // T0 = in0 & in1
        wr(12'(1 << 2) | 1, 32'h0000_0040);   // T1 = ~in2 (col 38)
        wr(12'(2 << 2) | 0, 32'h0000_0008);   // T2 = in3 ...
        wr(12'(2 << 2) | 1, 32'h0000_0100);   //      & ~in4 (col 40)
        wr(12'(4 << 2) | 0, 32'h0000_0020);   // T4 = in5, left disabled
        wr(12'(5 << 2) | 0, 32'h0000_0040);   // T5 = in6 ...
        wr(12'(5 << 2) | 1, 32'h0000_0400);   //      & ~in6
        wr(12'(85 << 2) | 1, 32'h0000_0008);  // T85 = in35
        wr(12'(6 << 2) | 2, 32'h0000_0080);   // T6 = ~in35 (col 71)
        wr(12'(7 << 2) | 3, 32'hFFFF_FFFF);   // R9: word 3 is ignored, T7 stays empty
        // enables
        wr(12'h400, 32'h0000_00EF);           // T0,T1,T2,T3,T5,T6,T7
        wr(12'h402, 32'h0020_0000);           // T85
        // slots: {valid, idx}
        wr(slot_a(0, 0), 32'h80);             // S0 <- T0
        wr(slot_a(1, 0), 32'h80);             // S1 <- T0 (shared)
        wr(slot_a(1, 15), 32'h81);            // S1 <- T1 via last slot
        wr(slot_a(3, 3), 32'h83);             // S3 <- T3 (empty mask)
        wr(slot_a(4, 0), 32'h84);             // S4 <- T4 (disabled)
        wr(slot_a(5, 0), 32'h85);             // S5 <- T5 (both polarities)
        wr(slot_a(6, 0), 32'h82);             // S6 <- T2
        wr(slot_a(7, 0), 32'h80 | 100);       // S7 <- index 100
        wr(slot_a(7, 1), 32'hFF);             // S7 <- index 127
        wr(slot_a(8, 0), 32'h80 | 85);        // S8 <- T85
        wr(slot_a(9, 0), 32'h86);             // S9 <- T6
        wr(slot_a(10, 0), 32'h03);            // S10 slot invalid
        wr(slot_a(11, 0), 32'h87);            // S11 <- T7
        wr(slot_a(15, 0), 32'h80);
        wr(slot_a(15, 1), 32'h81);
        wr(slot_a(15, 2), 32'h82);
        wr(slot_a(15, 3), 32'h80 | 85);
        for (int k = 4; k < 16; k++) wr(slot_a(15, k), 32'h84);
        wr(12'hC00, 32'h0000_0083);           // R9: region 3 ignored

        // vector table
        for (int i = 0; i < 7; i++) begin
            apply(VEC[i][51:16]);
            check($sformatf("R2/R5 vector %0d", i), sum_o, VEC[i][15:0]);
        end

        // R9: ignored writes left S0 following T0 and S11 constant
        apply(36'h0);
        check("R9 S0 untouched by region 3", {15'b0, sum_o[0]}, 16'h0000);
        check("R9 S11 word 3 ignored", {15'b0, sum_o[11]}, 16'h0001);
        // R3: empty-mask term is 1 under all ones too
        apply('1);
        check("R3 empty mask", {15'b0, sum_o[3]}, 16'h0001);
        // R6 / R8 / R5 invalid slot
        check("R6 empty S2", {15'b0, sum_o[2]}, 16'h0000);
        check("R8 index past pool", {15'b0, sum_o[7]}, 16'h0000);
        check("R5 invalid slot", {15'b0, sum_o[10]}, 16'h0000);

        // R10: presented write with we low changes nothing
        wr(slot_a(2, 0), 32'h83, 1'b0);
        apply(36'h0);
        check("R10 no write when we low", {15'b0, sum_o[2]}, 16'h0000);
        wr(slot_a(2, 0), 32'h83);
        #5 check("R10 write visible next evaluation", {15'b0, sum_o[2]}, 16'h0001);
        // R10: combinational follow of inputs without a clock edge
        @(negedge clk);
        in_sig = 36'h3;
        #3 check("R10 same-cycle input follow", {15'b0, sum_o[0]}, 16'h0001);
        in_sig = 36'h1;
        #3 check("R10 same-cycle input drop", {15'b0, sum_o[0]}, 16'h0000);

        // R1: reset clears loaded configuration
        @(negedge clk);
        rst_n = 1'b0;
        in_sig = '1;
        @(negedge clk);
        rst_n = 1'b1;
        #5 check("R1 reset clears config", sum_o, 16'h0000);
        apply(36'h0);
        check("R1 reset clears config zero in", sum_o, 16'h0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule